// File: doc/BRIEF.md
# Word Transfer Engine with Compare Mode

The engine moves 16-bit words between memory and a device-side stream. Each transfer starts from a 22-bit byte address, which is built from a 6-bit extension field above a 16-bit base field. It counts against a word counter held in two's complement, so the counter rises toward zero. A start command carries the operation, a requested byte count, the counter, the two address fields and an address-freeze option. The engine then runs one word per clock for as long as both the memory port and the device stream are ready.

There are three operations:

- **Memory read:** memory words are streamed out to the device.
- **Memory write:** device words are written into memory.
- **Compare:** each device word is compared with memory and the engine stops at the first difference, recording whether that word sat at an odd or an even byte address.

Memory existence is sampled only at the start of each page-bounded segment. A missing page stops the transfer with a flag set.

At the end, a one-cycle completion pulse is raised. The updated address fields, the counter, the byte total and the error flags remain on the outputs until the next start.

Top module: `wdma_engine`

## Requirements
- R1: A start request is taken only while the engine is idle. A start raised while a transfer runs changes neither that transfer nor its results.
- R2: The effective byte count is the requested count rounded down to even, limited to (65536 − counter) × 2. A zero effective count raises the completion pulse in the cycle after the start edge, and no memory or device beat takes place.
- R3: The working address is {extension, base}, 22 bits wide. It advances by 2 after each moved word, wraps modulo 2^22 and carries from the base field into the extension field. The outputs show the low 16 bits as the base field and the next 6 bits as the extension field.
- R4: When the address-freeze option is set at start, every word of the transfer uses the start address.
- R5: A transfer is split into segments that end at a page boundary of 2^PAGE_LG2 bytes (the first segment of an odd address holds ceil((page − offset)/2) words). The memory existence input is examined only on the first beat of each segment. If it is low there, the engine stops, sets the missing-memory flag and moves no word on that beat. A low existence input on any other beat has no effect.
- R6: In compare mode, every device word examined is captured in the data buffer. On the first word that differs from memory, the engine stops without counting or advancing past that word. It sets the odd flag if address bit 0 is 1, or the even flag otherwise; only one of the two is ever set.
- R7: At completion, the counter output equals the start counter plus the number of words moved, modulo 2^16. The byte total equals twice that number.
- R8: Operation codes are 00 for memory read, 01 for memory write, and 10 or 11 for compare. A read delivers memory words to the device stream in address order. A write stores each device word at the current address.
- R9: The completion pulse lasts exactly one cycle and appears in the cycle after the edge of the final beat or stop. Busy is low in that cycle, and all error flags are cleared by each accepted start.
- R10: With memory and device always ready, one word is moved every clock. A transfer of N words with no error raises its completion pulse N + 1 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start request |
| startOp | input | 2 | Operation code |
| startBytes | input | 18 | Requested byte count |
| startWc | input | 16 | Starting word counter (two's complement) |
| startBa | input | 16 | Starting base address field |
| startBae | input | 6 | Starting extension address field |
| startInhibit | input | 1 | Address-freeze option |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | 22 | Memory byte address |
| memWdata | output | 16 | Memory write data |
| memReady | input | 1 | Memory accepts a beat this cycle |
| memExists | input | 1 | Addressed memory exists |
| memRdata | input | 16 | Memory read data for the current address |
| devOutValid | output | 1 | Word offered to the device (read) |
| devOutData | output | 16 | Word to the device |
| devOutReady | input | 1 | Device takes a word |
| devInValid | input | 1 | Device offers a word (write, compare) |
| devInData | input | 16 | Word from the device |
| devInReady | output | 1 | Engine takes the device word |
| busy | output | 1 | Transfer in progress |
| doneP | output | 1 | Completion pulse |
| bytesDone | output | 18 | Bytes moved in the last transfer |
| wcOut | output | 16 | Word counter |
| baOut | output | 16 | Base address field |
| baeOut | output | 6 | Extension address field |
| dataBuf | output | 16 | Last device word examined in compare mode |
| nxmErr | output | 1 | Missing-memory flag |
| wceErr | output | 1 | Compare miss flag |
| wceOdd | output | 1 | Miss was at an odd byte address |
| wceEven | output | 1 | Miss was at an even byte address |

## Verification
A wrong internal state shows up at the ports within a few cycles:

- **Segment counter:** a wrong value moves the beat on which existence is sampled, so a missing page is flagged one or more words early or late. This shows as a wrong word count and address on the very next completion pulse.
- **Address register:** a corrupted value shows on memAddr at the next beat and in the memory contents or received stream.
- **Remaining-word counter:** a stale value shifts the completion pulse by whole cycles, which the no-stall runs time exactly.

Sweeps over start offsets, lengths, stall patterns and all operations compare every output against arithmetic expectations.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_CHECK  = 2'b10,
    OP_CHECKB = 2'b11
  } opKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // accept a new start
    logic step;     // one word moved
    logic capture;  // compare word examined
    logic setNxm;   // missing memory at segment start
    logic setWce;   // compare miss
  } strobe_t;

endpackage

// File: rtl/wdma_ctrl.sv
module wdma_ctrl
  import wdma_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int PAGE_LG2 = 13,
  localparam int BYTES_W = WORD_W + 2,
  localparam int WORDS_W = WORD_W + 1,
  localparam int SEG_W   = PAGE_LG2 + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic [1:0]         startOp,
  input  logic [BYTES_W-1:0] startBytes,
  input  logic [WORD_W-1:0]  startWc,
  input  logic [PAGE_LG2-1:0] pageOff,
  input  logic               memReady,
  input  logic               memExists,
  input  logic               devOutReady,
  input  logic               devInValid,
  input  logic               cmpMiss,
  output strobe_t            strobe,
  output logic               memValid,
  output logic               memWrite,
  output logic               devOutValid,
  output logic               devInReady,
  output logic               busy,
  output logic               doneP
);

  localparam int PAGE_BYTES = 1 << PAGE_LG2;
  localparam int HALF_PAGE  = PAGE_BYTES / 2;

  opKind_t              opQ;
  logic                 running;
  logic [WORDS_W-1:0]   wordsLeft;
  logic [SEG_W-1:0]     segLeft;
  logic                 segFirst;
  logic                 doneQ;

  // Effective count at start
  logic [WORD_W:0]      wcRoom;
  logic [BYTES_W-1:0]   roomBytes;
  logic [BYTES_W-1:0]   evenReq;
  logic [BYTES_W-1:0]   effBytes;
  logic                 accept;

  always_comb begin
    wcRoom    = {1'b0, ~startWc} + {{WORD_W{1'b0}}, 1'b1};
    roomBytes = {wcRoom, 1'b0};
    evenReq   = {startBytes[BYTES_W-1:1], 1'b0};
    effBytes  = (evenReq < roomBytes) ? evenReq : roomBytes;
    accept    = startValid && !running;
  end

  // Segment length from the page offset
  logic [SEG_W:0]   spanSum;
  logic [SEG_W-1:0] pageSpan;
  logic [SEG_W-1:0] firstSeg;
  logic [SEG_W-1:0] curSeg;

  always_comb begin
    spanSum  = (SEG_W+1)'(PAGE_BYTES) - {2'b00, pageOff} + {{SEG_W{1'b0}}, 1'b1};
    pageSpan = spanSum[SEG_W:1];
    firstSeg = (WORDS_W'(pageSpan) < wordsLeft) ? pageSpan : wordsLeft[SEG_W-1:0];
    curSeg   = segFirst ? firstSeg : segLeft;
  end

  // Beat decode
  logic isRead, isCheck, peerReady, existOk, beat, miss;
  logic stepNow, nxmNow, wceNow, lastNow, endNow;

  always_comb begin
    isRead    = (opQ == OP_READ);
    isCheck   = opQ[1];
    peerReady = isRead ? devOutReady : devInValid;
    memValid  = running && peerReady;
    existOk   = !segFirst || memExists;
    beat      = memValid && memReady;
    miss      = isCheck && cmpMiss;
    stepNow   = beat && existOk && !miss;
    nxmNow    = beat && !existOk;
    wceNow    = beat && existOk && miss;
    lastNow   = stepNow && (wordsLeft == {{(WORDS_W-1){1'b0}}, 1'b1});
    endNow    = nxmNow || wceNow || lastNow;

    devOutValid = running && isRead && memReady && existOk;
    devInReady  = running && !isRead && memReady && existOk;
    memWrite    = (opQ == OP_WRITE);

    strobe.load    = accept;
    strobe.step    = stepNow;
    strobe.capture = beat && existOk && isCheck;
    strobe.setNxm  = nxmNow;
    strobe.setWce  = wceNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ       <= OP_READ;
      running   <= 1'b0;
      wordsLeft <= '0;
      segLeft   <= '0;
      segFirst  <= 1'b1;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        opQ       <= opKind_t'(startOp);
        wordsLeft <= effBytes[BYTES_W-1:1];
        segLeft   <= '0;
        segFirst  <= 1'b1;
        if (effBytes == '0) doneQ   <= 1'b1;
        else                running <= 1'b1;
      end else if (running) begin
        if (stepNow) begin
          wordsLeft <= wordsLeft - {{(WORDS_W-1){1'b0}}, 1'b1};
          segLeft   <= curSeg - {{(SEG_W-1){1'b0}}, 1'b1};
          segFirst  <= (curSeg == {{(SEG_W-1){1'b0}}, 1'b1});
        end
        if (endNow) begin
          running <= 1'b0;
          doneQ   <= 1'b1;
        end
      end
    end
  end

  assign busy  = running;
  assign doneP = doneQ;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> !busy);

  a_r2_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (accept && effBytes == '0) |=> (doneP && !busy));

  a_r5_segment_bound: assert property (@(posedge clk) disable iff (!rstN)
    (running && !segFirst) |-> (segLeft <= SEG_W'(HALF_PAGE)));

  a_r10_full_rate: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memReady && memExists && !cmpMiss && peerReady)
      |-> (isRead ? devOutValid : devInReady));

endmodule

// File: rtl/wdma_path.sv
module wdma_path
  import wdma_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int EXT_W    = 6,
  parameter int PAGE_LG2 = 13,
  localparam int ADDR_W  = WORD_W + EXT_W,
  localparam int BYTES_W = WORD_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [WORD_W-1:0]   startWc,
  input  logic [WORD_W-1:0]   startBa,
  input  logic [EXT_W-1:0]    startBae,
  input  logic                startInhibit,
  input  logic [WORD_W-1:0]   devInData,
  input  logic [WORD_W-1:0]   memRdata,
  output logic                cmpMiss,
  output logic [PAGE_LG2-1:0] pageOff,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic [BYTES_W-1:0]  bytesDone,
  output logic [WORD_W-1:0]   wcOut,
  output logic [WORD_W-1:0]   baOut,
  output logic [EXT_W-1:0]    baeOut,
  output logic [WORD_W-1:0]   dataBuf,
  output logic                nxmErr,
  output logic                wceOdd,
  output logic                wceEven
);

  logic [ADDR_W-1:0]  addrQ;
  logic [WORD_W-1:0]  wcQ;
  logic [BYTES_W-1:0] bytesQ;
  logic [WORD_W-1:0]  dbQ;
  logic               inhQ, nxmQ, oddQ, evenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wcQ    <= '0;
      bytesQ <= '0;
      dbQ    <= '0;
      inhQ   <= 1'b0;
      nxmQ   <= 1'b0;
      oddQ   <= 1'b0;
      evenQ  <= 1'b0;
    end else if (strobe.load) begin
      addrQ  <= {startBae, startBa};
      wcQ    <= startWc;
      bytesQ <= '0;
      inhQ   <= startInhibit;
      nxmQ   <= 1'b0;
      oddQ   <= 1'b0;
      evenQ  <= 1'b0;
    end else begin
      if (strobe.step) begin
        if (!inhQ) addrQ <= addrQ + ADDR_W'(2);
        wcQ    <= wcQ + {{(WORD_W-1){1'b0}}, 1'b1};
        bytesQ <= bytesQ + BYTES_W'(2);
      end
      if (strobe.capture) dbQ <= devInData;
      if (strobe.setNxm)  nxmQ <= 1'b1;
      if (strobe.setWce) begin
        oddQ  <= addrQ[0];
        evenQ <= ~addrQ[0];
      end
    end
  end

  assign cmpMiss   = (devInData != memRdata);
  assign pageOff   = addrQ[PAGE_LG2-1:0];
  assign memAddr   = addrQ;
  assign memWdata  = devInData;
  assign bytesDone = bytesQ;
  assign wcOut     = wcQ;
  assign baOut     = addrQ[WORD_W-1:0];
  assign baeOut    = addrQ[ADDR_W-1:WORD_W];
  assign dataBuf   = dbQ;
  assign nxmErr    = nxmQ;
  assign wceOdd    = oddQ;
  assign wceEven   = evenQ;

  a_r3_addr_advance: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !inhQ) |=> (memAddr == $past(memAddr) + ADDR_W'(2)));

  a_r4_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && inhQ) |=> $stable(memAddr));

  a_r1_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> ($stable(memAddr) && $stable(wcOut) && $stable(bytesDone)));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |=> (wcOut == $past(wcOut) + WORD_W'(1)));

  a_r6_one_side: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wceOdd, wceEven}));

endmodule

// File: rtl/wdma_engine.sv
module wdma_engine
  import wdma_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int EXT_W    = 6,
  parameter int PAGE_LG2 = 13,
  localparam int ADDR_W  = WORD_W + EXT_W,
  localparam int BYTES_W = WORD_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic [1:0]         startOp,
  input  logic [BYTES_W-1:0] startBytes,
  input  logic [WORD_W-1:0]  startWc,
  input  logic [WORD_W-1:0]  startBa,
  input  logic [EXT_W-1:0]   startBae,
  input  logic               startInhibit,
  output logic               memValid,
  output logic               memWrite,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  memWdata,
  input  logic               memReady,
  input  logic               memExists,
  input  logic [WORD_W-1:0]  memRdata,
  output logic               devOutValid,
  output logic [WORD_W-1:0]  devOutData,
  input  logic               devOutReady,
  input  logic               devInValid,
  input  logic [WORD_W-1:0]  devInData,
  output logic               devInReady,
  output logic               busy,
  output logic               doneP,
  output logic [BYTES_W-1:0] bytesDone,
  output logic [WORD_W-1:0]  wcOut,
  output logic [WORD_W-1:0]  baOut,
  output logic [EXT_W-1:0]   baeOut,
  output logic [WORD_W-1:0]  dataBuf,
  output logic               nxmErr,
  output logic               wceErr,
  output logic               wceOdd,
  output logic               wceEven
);

  strobe_t             strobe;
  logic                cmpMiss;
  logic [PAGE_LG2-1:0] pageOff;

  wdma_ctrl #(.WORD_W(WORD_W), .PAGE_LG2(PAGE_LG2)) ctrl (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .startOp(startOp), .startBytes(startBytes), .startWc(startWc),
    .pageOff(pageOff), .memReady(memReady), .memExists(memExists),
    .devOutReady(devOutReady), .devInValid(devInValid), .cmpMiss(cmpMiss),
    .strobe(strobe), .memValid(memValid), .memWrite(memWrite),
    .devOutValid(devOutValid), .devInReady(devInReady), .busy(busy), .doneP(doneP)
  );

  wdma_path #(.WORD_W(WORD_W), .EXT_W(EXT_W), .PAGE_LG2(PAGE_LG2)) path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startWc(startWc), .startBa(startBa), .startBae(startBae), .startInhibit(startInhibit),
    .devInData(devInData), .memRdata(memRdata), .cmpMiss(cmpMiss), .pageOff(pageOff),
    .memAddr(memAddr), .memWdata(memWdata), .bytesDone(bytesDone), .wcOut(wcOut),
    .baOut(baOut), .baeOut(baeOut), .dataBuf(dataBuf), .nxmErr(nxmErr),
    .wceOdd(wceOdd), .wceEven(wceEven)
  );

  assign devOutData = memRdata;
  assign wceErr     = wceOdd | wceEven;

  a_r7_even_total: assert property (@(posedge clk) disable iff (!rstN)
    bytesDone[0] == 1'b0);

  a_r9_flags_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> (!nxmErr && !wceErr));

endmodule

// File: tb/wdma_engine_test.sv
module wdma_engine_test;

  localparam int PL   = 3;
  localparam int PG   = 1 << PL;
  localparam int AMSK = 32'h3FFFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        startValid = 1'b0;
  logic [1:0]  startOp = 2'b00;
  logic [17:0] startBytes = '0;
  logic [15:0] startWc = '0;
  logic [15:0] startBa = '0;
  logic [5:0]  startBae = '0;
  logic        startInhibit = 1'b0;
  logic        memValid, memWrite;
  logic [21:0] memAddr;
  logic [15:0] memWdata;
  logic        memReady = 1'b0;
  logic        memExists;
  logic [15:0] memRdata;
  logic        devOutValid;
  logic [15:0] devOutData;
  logic        devOutReady = 1'b0;
  logic        devInValid = 1'b0;
  logic [15:0] devInData = '0;
  logic        devInReady, busy, doneP;
  logic [17:0] bytesDone;
  logic [15:0] wcOut, baOut, dataBuf;
  logic [5:0]  baeOut;
  logic        nxmErr, wceErr, wceOdd, wceEven;

  logic [15:0] mem [32];
  int existLimit = 32'h400000;

  assign memExists = (int'(memAddr) < existLimit);
  assign memRdata  = mem[memAddr[5:1]];

  wdma_engine #(.PAGE_LG2(PL)) uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .startBytes(startBytes), .startWc(startWc), .startBa(startBa), .startBae(startBae),
    .startInhibit(startInhibit), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady), .memExists(memExists),
    .memRdata(memRdata), .devOutValid(devOutValid), .devOutData(devOutData),
    .devOutReady(devOutReady), .devInValid(devInValid), .devInData(devInData),
    .devInReady(devInReady), .busy(busy), .doneP(doneP), .bytesDone(bytesDone),
    .wcOut(wcOut), .baOut(baOut), .baeOut(baeOut), .dataBuf(dataBuf), .nxmErr(nxmErr),
    .wceErr(wceErr), .wceOdd(wceOdd), .wceEven(wceEven)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R9: actual hung expected completion");
    summary();
    $finish;
  end

  task automatic runOp(input int op, input int bytes, input int wc, input int a0,
                       input bit inh, input int missAt, input int stall, input bit poke,
                       input string tag);
    int bc, words, n, a, segLeft, seg, iters, nGot, idx, bad;
    bit nxmE, oddE, evenE, done, touched;
    logic [15:0] dbE;
    logic [15:0] src [64];
    logic [15:0] expMem [32];
    logic [15:0] expRd [64];
    logic [15:0] gotRd [64];

    bc = bytes & ~1;
    if (bc > (65536 - wc) * 2) bc = (65536 - wc) * 2;
    words = bc / 2;
    for (int k = 0; k < 64; k++) begin
      int ak;
      ak = inh ? a0 : ((a0 + 2 * k) & AMSK);
      if (op >= 2) src[k] = mem[(ak >> 1) & 31] ^ ((k == missAt) ? 16'h0101 : 16'h0000);
      else         src[k] = 16'(k * 4951 + a0);
    end
    for (int k = 0; k < 32; k++) expMem[k] = mem[k];

    a = a0; n = 0; segLeft = 0;
    nxmE = 0; oddE = 0; evenE = 0; touched = 0; dbE = dataBuf;
    while (n < words) begin
      if (segLeft == 0) begin
        seg = (PG - (a % PG) + 1) / 2;
        if (seg > words - n) seg = words - n;
        if (a >= existLimit) begin nxmE = 1; break; end
        segLeft = seg;
      end
      if (op >= 2) begin
        dbE = src[n];
        touched = 1;
        if (expMem[(a >> 1) & 31] != src[n]) begin
          oddE = a[0];
          evenE = !a[0];
          break;
        end
      end
      if (op == 0) expRd[n] = expMem[(a >> 1) & 31];
      if (op == 1) expMem[(a >> 1) & 31] = src[n];
      n++;
      segLeft--;
      if (!inh) a = (a + 2) & AMSK;
    end

    @(negedge clk);
    startValid   = 1'b1;
    startOp      = 2'(op);
    startBytes   = 18'(bytes);
    startWc      = 16'(wc);
    startBa      = 16'(a0);
    startBae     = 6'(a0 >> 16);
    startInhibit = inh;
    memReady = 1'b0; devOutReady = 1'b0; devInValid = 1'b0;

    iters = 0; nGot = 0; idx = 0; done = 0;
    while (!done && iters < 400) begin
      @(negedge clk);
      iters++;
      startValid = poke && (iters == 2);
      if (poke) begin
        startWc = 16'h1234; startBa = 16'h0002; startBae = 6'h01; startOp = 2'b01;
        startBytes = 18'd40;
      end
      memReady    = (stall == 0) || (((iters * 3 + stall) % 4) != 0);
      devOutReady = (stall == 0) || (((iters * 5 + stall) % 3) != 0);
      devInValid  = (stall == 0) || (((iters * 7 + stall) % 5) != 1);
      devInData   = src[idx & 63];
      #1;
      if (doneP) done = 1;
      else begin
        if (devOutValid && devOutReady) begin
          gotRd[nGot & 63] = devOutData;
          nGot++;
        end
        if (devInValid && devInReady) begin
          if (op == 1) mem[memAddr[5:1]] = devInData;
          idx++;
        end
      end
    end
    startValid = 1'b0;

    chk({tag, " R9 completion seen"}, 32'(done), 32'd1);
    chk({tag, " R9 idle at completion"}, 32'(busy), 32'd0);
    chk({tag, " R7 word counter"}, 32'(wcOut), 32'((wc + n) & 16'hFFFF));
    chk({tag, " R7 byte total"}, 32'(bytesDone), 32'(2 * n));
    chk({tag, " R3 final address"}, {10'd0, baeOut, baOut}, 32'(a));
    chk({tag, " R5 missing-memory flag"}, 32'(nxmErr), 32'(nxmE));
    chk({tag, " R6 odd/even flags"}, {29'd0, wceErr, wceOdd, wceEven},
        {29'd0, oddE | evenE, oddE, evenE});
    if (op >= 2 && touched) chk({tag, " R6 data buffer"}, 32'(dataBuf), 32'(dbE));
    if (op == 0) begin
      bad = 0;
      for (int k = 0; k < n; k++) if (gotRd[k] !== expRd[k]) bad++;
      chk({tag, " R8 read word count"}, 32'(nGot), 32'(n));
      chk({tag, " R8 read data mismatches"}, 32'(bad), 32'd0);
    end
    if (op == 1) begin
      bad = 0;
      for (int k = 0; k < 32; k++) if (mem[k] !== expMem[k]) bad++;
      chk({tag, " R8 memory contents mismatches"}, 32'(bad), 32'd0);
    end
    if (stall == 0 && !nxmE && !oddE && !evenE)
      chk({tag, " R10 cycles to completion"}, 32'(iters), 32'(words + 1));
    @(negedge clk);
    #1;
    chk({tag, " R9 pulse length"}, 32'(doneP), 32'd0);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) mem[k] = 16'(k * 241) ^ 16'h5A5A;
    repeat (3) @(negedge clk);
    #1;
    chk("reset R9 busy", 32'(busy), 32'd0);
    chk("reset R9 pulse", 32'(doneP), 32'd0);
    chk("reset R7 totals", {14'd0, bytesDone}, 32'd0);
    chk("reset R5 R6 flags", {29'd0, nxmErr, wceOdd, wceEven}, 32'd0);
    rstN = 1'b1;

    // Sweep: operations x start offsets x lengths, mixed stalls
    for (int op = 0; op < 3; op++)
      for (int off = 0; off < 8; off++)
        for (int w = 0; w < 10; w++)
          runOp(op, 2 * w + (w % 2), 16'hFF00, 8 + off, 1'b0,
                (op == 2 && w > 0 && off % 2 == 1) ? w / 2 : -1,
                (off + w) % 3, 1'b0, "sweep");

    // Compare code 11 behaves as compare
    runOp(3, 10, 16'hFFF0, 16, 1'b0, -1, 0, 1'b0, "R8 code11");
    // Even-address miscompare
    runOp(2, 12, 16'hFFF0, 32, 1'b0, 2, 0, 1'b0, "R6 even miss");

    // Existence sampled only at segment starts
    existLimit = 32'h14;
    runOp(0, 12, 16'hFFF0, 32'h10, 1'b0, -1, 0, 1'b0, "R5 mid-segment ignored");
    runOp(1, 12, 16'hFFF0, 32'h10, 1'b0, -1, 1, 1'b0, "R5 write stop");
    existLimit = 32'h10;
    runOp(2, 8, 16'hFFF0, 32'h10, 1'b0, -1, 0, 1'b0, "R5 first word");
    existLimit = 32'h400000;

    // Address freeze
    runOp(1, 10, 16'hFFF0, 32'h0A, 1'b1, -1, 0, 1'b0, "R4 write frozen");
    runOp(0, 14, 16'hFFF0, 32'h13, 1'b1, -1, 2, 1'b0, "R4 read frozen");

    // Count limits
    runOp(0, 20, 16'hFFFD, 32'h20, 1'b0, -1, 0, 1'b0, "R2 counter limit");
    runOp(1, 7, 16'h0000, 32'h20, 1'b0, -1, 0, 1'b0, "R2 odd request");
    runOp(0, 1, 16'h0000, 32'h20, 1'b0, -1, 0, 1'b0, "R2 one byte");
    runOp(1, 30, 16'hFFFF, 32'h04, 1'b0, -1, 0, 1'b0, "R7 counter wrap");

    // Carry into extension and full wrap
    runOp(0, 8, 16'hFFF0, 32'h3FFFC, 1'b0, -1, 0, 1'b0, "R3 carry");
    runOp(1, 6, 16'hFFF0, 32'h3FFFFE, 1'b0, -1, 0, 1'b0, "R3 wrap");

    // Start while busy
    runOp(0, 12, 16'hFFF0, 32'h20, 1'b0, -1, 0, 1'b1, "R1 busy start");
    runOp(2, 12, 16'hFFF0, 32'h21, 1'b0, -1, 1, 1'b1, "R1 busy start compare");

    summary();
    $finish;
  end

endmodule